// File: doc/BRIEF.md
# Double-Buffered Engine Control Register

This block holds one control word for a hardware engine that runs on its own schedule, apart from CPU accesses. A CPU write does not reach the engine straight away. It goes into a holding buffer and raises a pending flag. The held word moves into the active register, which drives the engine, in one of two cases: the engine reports that the operation using the old word has ended, or the engine is idle. The engine therefore never sees its control word change in the middle of an operation.

The CPU side is a synchronous port with a request, a write enable, a 2-bit address, write data and registered read data. Firmware can read the held word, read the active word and read a control/status word that carries the pending flag. For debug work, a bypass bit in the control/status word makes CPU writes land in the active register at once.

Top module: `dbuf_ctrl_reg`

## Requirements
- R1: After reset, the held word and the active word both equal the parameter RESET_VAL. The pending flag and the bypass bit are 0, and cpu_rdata_o is 0.
- R2: With bypass clear, a write to address 0 while eng_busy_i is high and eng_done_i is low leaves eng_active_o unchanged and sets the pending flag.
- R3: While the pending flag is set, a cycle with eng_done_i high copies the held word into the active register at that clock edge.
- R4: If the pending flag is set and eng_busy_i is low, the transfer happens at the next clock edge, with no done strobe needed.
- R5: A second write to address 0 before a transfer replaces the held word. Only the latest word reaches the active register.
- R6: A read of address 0 returns the last word written there. Read data appears on cpu_rdata_o one clock after the request cycle.
- R7: A read of address 1 returns the active word. Writes to address 1 have no effect.
- R8: Address 2 holds the control/status word. Bit 0 is the pending flag and is read-only; a write to bit 0 is ignored. Bit 1 is the bypass enable and can be read and written. All other bits read 0.
- R9: With bypass set, a write to address 0 loads the held word and the active word at the same edge and clears the pending flag.
- R10: Suppose a write to address 0 and a transfer happen in the same cycle. The word held before that cycle goes to the active register, and the new word stays held with the pending flag set.
- R11: A done strobe while nothing is pending leaves the active word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request |
| cpu_we_i | input | 1 | Write enable (1 = write) |
| cpu_addr_i | input | 2 | 0: held word, 1: active word, 2: control/status |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, one cycle after the request |
| eng_busy_i | input | 1 | Engine is running an operation |
| eng_done_i | input | 1 | Operation-complete strobe |
| eng_active_o | output | DATA_W | Active control word driven to the engine |

## Verification
The hardest case to reach is R10: a CPU write that lands in exactly the cycle a done strobe fires while an older word is already held. The stimulus table first writes during busy to leave a word held. It then drives the done strobe and a second write in one vector, and checks that the older word becomes active and that the newer one follows only after the engine drops busy. The bypass and replace cases are reached the same way, by placing a write against a known busy/done pattern.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [1:0] {
    ADDR_HELD = 2'd0,
    ADDR_ACT  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_RSVD = 2'd3
  } dbuf_addr_e;

  localparam int CTRL_PEND_BIT = 0;
  localparam int CTRL_BYP_BIT  = 1;
endpackage

// File: rtl/dbuf_bus_if.sv
module dbuf_bus_if
  import dbuf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic              byp_wbit_i,
  input  logic [DATA_W-1:0] held_i,
  input  logic [DATA_W-1:0] act_i,
  input  logic              pend_i,
  output logic              held_wr_o,
  output logic              byp_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              byp_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rmux;
  logic              ctrl_wr;
  logic              rd;

  assign held_wr_o = req_i && we_i && (addr_i == ADDR_HELD);
  assign ctrl_wr   = req_i && we_i && (addr_i == ADDR_CTRL);
  assign rd        = req_i && !we_i;

  always_comb begin
    rmux = '0;
    case (addr_i)
      ADDR_HELD: rmux = held_i;
      ADDR_ACT:  rmux = act_i;
      ADDR_CTRL: begin
        rmux[CTRL_PEND_BIT] = pend_i;
        rmux[CTRL_BYP_BIT]  = byp_q;
      end
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_wr) byp_q <= byp_wbit_i;
      if (rd) rdata_q <= rmux;
    end
  end

  assign byp_o   = byp_q;
  assign rdata_o = rdata_q;

  assert_held_readback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_HELD) |=> rdata_o == $past(held_i));

  assert_act_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_ACT) |=> rdata_o == $past(act_i));

  assert_ctrl_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == ADDR_CTRL) |=> rdata_o[DATA_W-1:2] == '0);
endmodule

// File: rtl/dbuf_hold.sv
module dbuf_hold #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              byp_i,
  input  logic              xfer_i,
  output logic [DATA_W-1:0] held_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] held_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= RESET_VAL;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) held_q <= wdata_i;
      // new write wins over a transfer of the older word
      if (wr_i)        pend_q <= !byp_i;
      else if (xfer_i) pend_q <= 1'b0;
    end
  end

  assign held_o = held_q;
  assign pend_o = pend_q;

  assert_write_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !byp_i) |=> (pend_o && held_o == $past(wdata_i)));

  assert_pend_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !wr_i) |=> !pend_o);

  assert_byp_no_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && byp_i) |=> !pend_o);
endmodule

// File: rtl/dbuf_active.sv
module dbuf_active #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] held_i,
  input  logic              byp_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              xfer_o,
  output logic [DATA_W-1:0] active_o
);
  logic [DATA_W-1:0] active_q;

  assign xfer_o = pend_i && (done_i || !busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= RESET_VAL;
    else if (byp_wr_i) active_q <= wdata_i;
    else if (xfer_o)   active_q <= held_i;
  end

  assign active_o = active_q;

  assert_stable_no_xfer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_o && !byp_wr_i) |=> $stable(active_o));

  assert_xfer_copies_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !byp_wr_i) |=> active_o == $past(held_i));

  assert_bypass_direct_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_wr_i |=> active_o == $past(wdata_i));

  assert_idle_no_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !busy_i && !byp_wr_i) |=> active_o == $past(held_i));
endmodule

// File: rtl/dbuf_ctrl_reg.sv
module dbuf_ctrl_reg
  import dbuf_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  output logic [DATA_W-1:0] eng_active_o
);
  logic              held_wr;
  logic              byp;
  logic              pend;
  logic              xfer;
  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] active;

  dbuf_bus_if #(.DATA_W(DATA_W)) i_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (cpu_req_i),
    .we_i       (cpu_we_i),
    .addr_i     (cpu_addr_i),
    .byp_wbit_i (cpu_wdata_i[CTRL_BYP_BIT]),
    .held_i     (held),
    .act_i      (active),
    .pend_i     (pend),
    .held_wr_o  (held_wr),
    .byp_o      (byp),
    .rdata_o    (cpu_rdata_o)
  );

  dbuf_hold #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (held_wr),
    .wdata_i (cpu_wdata_i),
    .byp_i   (byp),
    .xfer_i  (xfer),
    .held_o  (held),
    .pend_o  (pend)
  );

  dbuf_active #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) i_active (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .busy_i   (eng_busy_i),
    .done_i   (eng_done_i),
    .held_i   (held),
    .byp_wr_i (held_wr && byp),
    .wdata_i  (cpu_wdata_i),
    .xfer_o   (xfer),
    .active_o (active)
  );

  assign eng_active_o = active;

  assert_done_idle_noop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend && !(cpu_req_i && cpu_we_i)) |=> $stable(eng_active_o));

  assert_coincident_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && eng_done_i && held_wr && !byp) |=> (pend && eng_active_o == $past(held)));
endmodule

// File: tb/test_dbuf_ctrl_reg.sv
module test_dbuf_ctrl_reg;
  localparam int          DW  = 32;
  localparam logic [31:0] RST = 32'h0000_00A5;

  typedef struct packed {
    logic        busy;
    logic        done;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] exp_act;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b1, 32'h11, 32'hA5}, // R2 write held while busy
    '{1'b1, 1'b0, 1'b0, 32'h0,  32'hA5}, // R2
    '{1'b1, 1'b0, 1'b1, 32'h22, 32'hA5}, // R5 replace
    '{1'b1, 1'b1, 1'b0, 32'h0,  32'h22}, // R3 done transfers latest (R5)
    '{1'b1, 1'b0, 1'b0, 32'h0,  32'h22},
    '{1'b1, 1'b1, 1'b0, 32'h0,  32'h22}, // R11 done with nothing pending
    '{1'b0, 1'b0, 1'b1, 32'h33, 32'h22}, // R4 write while idle
    '{1'b0, 1'b0, 1'b0, 32'h0,  32'h33}, // R4 next edge
    '{1'b1, 1'b0, 1'b1, 32'h44, 32'h33},
    '{1'b1, 1'b1, 1'b1, 32'h55, 32'h44}, // R10 older word moves
    '{1'b1, 1'b0, 1'b0, 32'h0,  32'h44}, // R10 newer still held
    '{1'b0, 1'b0, 1'b0, 32'h0,  32'h55}  // R10 newer follows on idle
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, busy = 1'b0, done = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, active;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dbuf_ctrl_reg #(.DATA_W(DW), .RESET_VAL(RST)) i_dbuf_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .eng_busy_i(busy), .eng_done_i(done), .eng_active_o(active)
  );

  task automatic chk(input string req_tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic d, input logic rq, input logic w,
                     input logic [1:0] a, input logic [DW-1:0] wd);
    @(negedge clk);
    busy = b; done = d; req = rq; we = w; addr = a; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0; done = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [DW-1:0] exp);
    cyc(busy, 1'b0, 1'b1, 1'b0, a, '0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, '0);
    chk("R1 active", active, RST);
    rst_n = 1'b1;
    rd(2'd0, "R1 held", RST);
    rd(2'd1, "R1 act", RST);
    rd(2'd2, "R1 ctrl", 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].busy, VEC[i].done, VEC[i].wr, VEC[i].wr, 2'd0, VEC[i].wdata);
      chk($sformatf("R2-R5/R10/R11 vec%0d", i), active, VEC[i].exp_act);
    end

    rd(2'd0, "R6 held", 32'h55);
    rd(2'd1, "R7 act", 32'h55);
    rd(2'd2, "R8 ctrl idle", 32'h0);

    cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 32'h99);
    chk("R7 write ignored", active, 32'h55);
    rd(2'd1, "R7 act after write", 32'h55);

    cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 32'h66);
    rd(2'd0, "R6 held pending", 32'h66);
    rd(2'd2, "R8 pend bit", 32'h1);
    chk("R2 active kept", active, 32'h55);

    cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 32'hFFFF_FFFE);
    rd(2'd2, "R8 bypass bit", 32'h3);

    cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 32'h77);
    chk("R9 active direct", active, 32'h77);
    rd(2'd2, "R9 pend cleared", 32'h2);
    rd(2'd0, "R9 held", 32'h77);

    cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 32'h1);
    rd(2'd2, "R8 pend bit read-only", 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule